// File: doc/BRIEF.md
# Countdown Watchdog with APB Register Access

This block is a down-counting watchdog timer reached through an APB-style register interface. Software writes a reload number, then sets a single enable bit. That bit both starts the count and unmasks the interrupt. The counter moves down by one on each cycle in which an external divider pulses `tick_en`. When the count reaches zero a sticky raw status flag is raised, and on the following tick the counter restarts from the reload number. Any write to the clear register drops the flag and restarts the count. This is the periodic "kick" that keeps the watchdog quiet.

A build-time parameter selects a locking variant. In that variant, once software has set the enable bit, later control writes are ignored until the next reset. A runaway program therefore cannot switch the watchdog off.

Top module: `wdog_apb`

## Requirements
- R1: Register map, decoded on the full address. Each access is one cycle: a write acts in the cycle where `psel`, `penable` and `pwrite` are all high, and `pready` is always 1.
  - reload at 0x00, read/write.
  - current count at 0x04, read-only.
  - control at 0x08, enable in bit 0.
  - clear at 0x0C, write-only, reads 0.
  - raw status at 0x10, bit 0.
  - masked status at 0x14, bit 0.
  - Any other address reads 0, and writes to it or to read-only registers are ignored.
- R2: After reset, reload and count both read 0xFFFFFFFF, control reads 0, and both status registers read 0.
- R3: The count decreases by exactly one per `tick_en` cycle while the enable bit is 1. While the enable bit is 0 it holds, including straight after reset.
- R4: A reload-register write sets the count to the written number in the next cycle, whether or not counting is enabled. If a tick occurs in the same cycle, the write wins.
- R5: A control write that takes the enable bit from 0 to 1 reloads the count from the reload register. Clearing the enable bit freezes the count and leaves the raw status unchanged.
- R6: A tick that moves the count from 1 to 0 sets the raw status. The next tick with the count at 0 reloads the count from the reload register.
- R7: A write of any data to the clear register clears the raw status and reloads the count. If it coincides with the tick that would reach zero, the status stays clear and the count reloads.
- R8: With `LOCK_EN`=1, control writes are ignored once the enable bit is 1. Counting continues and control reads 1 until reset. With `LOCK_EN`=0, control writes always take effect.
- R9: `wdog_irq` and the masked status both equal the raw status ANDed with the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data (0 when not selected) |
| pready | output | 1 | Always 1, no wait states |
| tick_en | input | 1 | Count-step pulse from the external divider |
| wdog_irq | output | 1 | Interrupt, raw status gated by enable |

## Verification
Directed sequences first walk the count through enabled and frozen intervals, run it to zero and past zero, and kick it with clear writes. These sequences tell apart a counter that ignores the enable, one that fails to reload on re-enable, and one that reloads on the wrong tick. Collision cases then put a reload write or a clear write in the same cycle as a tick, including the tick that would reach zero, so the bench can see which event takes priority. A seeded random mix of writes, tick patterns and reads runs against both the plain and the locking build. Small reload numbers are used so that zero-crossings, a reload number of 0 and attempts to clear a locked enable come up often.

// File: rtl/wdog_pkg.sv
// Package wdog_pkg
// Shared register offsets and the write-strobe bundle passed from the
// address decoder to the counter core. Offsets are byte addresses.
package wdog_pkg;

    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_COUNT = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_CLEAR = 'h0C;
    localparam int OFF_RAW   = 'h10;
    localparam int OFF_MASK  = 'h14;

    // One-cycle write strobes, at most one high per cycle.
    typedef struct packed {
        logic load_we;
        logic ctrl_we;
        logic clr_we;
    } wdog_wr_t;

endpackage

// File: rtl/wdog_apb_dec.sv
// Module wdog_apb_dec
// Turns an APB access-phase write into one strobe per writable register.
// Assumes the full address is decoded; writes to unmapped or read-only
// offsets produce no strobe.
module wdog_apb_dec
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output wdog_wr_t          wr
);

    logic wr_phase;

    // Qualify a write to the access phase of a selected transfer.
    always_comb wr_phase = psel && penable && pwrite;

    // Match the address against each writable register.
    always_comb begin
        wr.load_we = wr_phase && (paddr == ADDR_W'(OFF_LOAD));
        wr.ctrl_we = wr_phase && (paddr == ADDR_W'(OFF_CTRL));
        wr.clr_we  = wr_phase && (paddr == ADDR_W'(OFF_CLEAR));
    end

endmodule

// File: rtl/wdog_rd_mux.sv
// Module wdog_rd_mux
// Read-data multiplexer. Returns zero for unmapped and write-only
// offsets and whenever the block is not selected. Purely combinational,
// so reads complete with no wait states.
module wdog_rd_mux
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              psel,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] load_q,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              en_q,
    input  logic              ris_q,
    output logic [DATA_W-1:0] prdata
);

    localparam logic [DATA_W-1:0] ZERO = '0;

    // Select the register addressed by paddr.
    always_comb begin
        prdata = ZERO;
        if (psel) begin
            if (paddr == ADDR_W'(OFF_LOAD))       prdata = load_q;
            else if (paddr == ADDR_W'(OFF_COUNT)) prdata = cnt_q;
            else if (paddr == ADDR_W'(OFF_CTRL))  prdata = {ZERO[DATA_W-1:1], en_q};
            else if (paddr == ADDR_W'(OFF_RAW))   prdata = {ZERO[DATA_W-1:1], ris_q};
            else if (paddr == ADDR_W'(OFF_MASK))  prdata = {ZERO[DATA_W-1:1], ris_q & en_q};
        end
    end

endmodule

// File: rtl/wdog_core.sv
// Module wdog_core
// Reload register, down counter, enable bit and sticky raw status.
// Priority on the count: reload write, then clear write, then an enable
// rise, then a tick. Assumes at most one write strobe per cycle.
// LOCK_EN=1 freezes the enable bit once it has been set, until reset.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit LOCK_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wdog_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              en_q,
    output logic              ris_q
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic ctrl_locked;
    logic en_rise;
    logic step;
    logic hit_zero;

    // Pick the variant: a locked enable holds once set.
    generate
        if (LOCK_EN) begin : g_lock
            always_comb ctrl_locked = en_q;
        end else begin : g_free
            always_comb ctrl_locked = 1'b0;
        end
    endgenerate

    // Derive the per-cycle events used by the registers below.
    always_comb begin
        en_rise  = wr.ctrl_we && !en_q && wdata[0];
        step     = en_q && tick;
        hit_zero = step && (cnt_q == ONE);
    end

    // Enable bit: written by software unless locked.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= 1'b0;
        else if (wr.ctrl_we && !ctrl_locked) en_q <= wdata[0];
    end

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)          load_q <= '1;
        else if (wr.load_we) load_q <= wdata;
    end

    // Down counter with its reload priorities.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '1;
        else if (wr.load_we)   cnt_q <= wdata;
        else if (wr.clr_we)    cnt_q <= load_q;
        else if (en_rise)      cnt_q <= load_q;
        else if (step)         cnt_q <= (cnt_q == '0) ? load_q : cnt_q - ONE;
    end

    // Sticky raw status: set on reaching zero, cleared by a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ris_q <= 1'b0;
        else if (wr.clr_we)                  ris_q <= 1'b0;
        else if (hit_zero && !wr.load_we)    ris_q <= 1'b1;
    end

    p_reset_vals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt_q == '1 && load_q == '1 && !en_q && !ris_q));

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr.load_we && !wr.ctrl_we && !wr.clr_we) |=> $stable(cnt_q));

    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr.load_we |=> cnt_q == $past(wdata));

    p_rise_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.ctrl_we && !en_q && wdata[0]) |=> cnt_q == $past(load_q));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick && cnt_q == ONE && !wr.load_we && !wr.clr_we) |=> ris_q);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr.clr_we |=> (!ris_q && cnt_q == $past(load_q)));

    generate
        if (LOCK_EN) begin : g_lock_chk
            p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                en_q |=> en_q);
        end
    endgenerate

endmodule

// File: rtl/wdog_apb.sv
// Module wdog_apb
// Top of the countdown watchdog: APB decode, counter core and read mux.
// Assumes tick_en is a single-cycle pulse in the pclk domain and that
// the bus master follows the two-phase APB transfer.
module wdog_apb
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter bit LOCK_EN = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              tick_en,
    output logic              wdog_irq
);

    wdog_wr_t          wr;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q;
    logic              en_q;
    logic              ris_q;

    wdog_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr      (wr)
    );

    wdog_core #(.DATA_W(DATA_W), .LOCK_EN(LOCK_EN)) u_core (
        .clk    (pclk),
        .rst_n  (presetn),
        .wr     (wr),
        .wdata  (pwdata),
        .tick   (tick_en),
        .load_q (load_q),
        .cnt_q  (cnt_q),
        .en_q   (en_q),
        .ris_q  (ris_q)
    );

    wdog_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .psel   (psel),
        .paddr  (paddr),
        .load_q (load_q),
        .cnt_q  (cnt_q),
        .en_q   (en_q),
        .ris_q  (ris_q),
        .prdata (prdata)
    );

    // Zero-wait-state bus and gated interrupt.
    always_comb begin
        pready   = 1'b1;
        wdog_irq = ris_q & en_q;
    end

    p_irq_gate_r9: assert property (@(posedge pclk) disable iff (!presetn)
        wdog_irq |-> (en_q && ris_q));

endmodule

// File: tb/wdog_apb_bench.sv
module wdog_apb_bench;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          pen = 1'b0;
    logic          pwr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          tick = 1'b0;
    logic [DW-1:0] rdata [2];
    logic          rdy [2];
    logic          irq [2];

    always #5 clk = ~clk;

    wdog_apb #(.ADDR_W(AW), .DATA_W(DW), .LOCK_EN(1'b0)) u_wdog_apb (
        .pclk(clk), .presetn(rst_n), .psel(sel[0]), .penable(pen), .pwrite(pwr),
        .paddr(addr), .pwdata(wdata), .prdata(rdata[0]), .pready(rdy[0]),
        .tick_en(tick), .wdog_irq(irq[0]));

    wdog_apb #(.ADDR_W(AW), .DATA_W(DW), .LOCK_EN(1'b1)) u_wdog_apb_lock (
        .pclk(clk), .presetn(rst_n), .psel(sel[1]), .penable(pen), .pwrite(pwr),
        .paddr(addr), .pwdata(wdata), .prdata(rdata[1]), .pready(rdy[1]),
        .tick_en(tick), .wdog_irq(irq[1]));

    // Reference model state, one set per instance (1 = locking build).
    logic [31:0] m_load [2];
    logic [31:0] m_val  [2];
    bit          m_en   [2];
    bit          m_ris  [2];
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_load[k] = 32'hFFFF_FFFF; m_val[k] = 32'hFFFF_FFFF;
            m_en[k] = 0; m_ris[k] = 0;
        end
    endtask

    // One clock of the requirement model for instance k.
    task automatic model_step(int k, bit wl, bit wc, bit wclr, logic [31:0] d, bit tk);
        bit old_en = m_en[k];
        bit rise = wc && !old_en && d[0];
        bit reach = old_en && tk && (m_val[k] == 32'd1);
        if (wc && !(k == 1 && old_en)) m_en[k] = d[0];
        if (wclr) m_ris[k] = 0;
        else if (reach && !wl) m_ris[k] = 1;
        if (wl) begin m_load[k] = d; m_val[k] = d; end
        else if (wclr || rise) m_val[k] = m_load[k];
        else if (old_en && tk) m_val[k] = (m_val[k] == 0) ? m_load[k] : m_val[k] - 1;
    endtask

    function automatic logic [31:0] exp_read(int k, logic [11:0] a);
        case (a)
            12'h000: return m_load[k];
            12'h004: return m_val[k];
            12'h008: return {31'd0, m_en[k]};
            12'h010: return {31'd0, m_ris[k]};
            12'h014: return {31'd0, m_ris[k] & m_en[k]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [11:0] a);
        case (a)
            12'h004: return "R3";
            12'h010: return "R6";
            12'h014: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance one clock with the given inputs already applied.
    task automatic edge_step(int k, bit wr_ok, bit tk);
        bit wl = wr_ok && addr == 12'h000;
        bit wc = wr_ok && addr == 12'h008;
        bit wclr = wr_ok && addr == 12'h00C;
        @(posedge clk);
        for (int j = 0; j < 2; j++)
            model_step(j, (j == k) && wl, (j == k) && wc, (j == k) && wclr, wdata, tk);
        @(negedge clk);
    endtask

    task automatic run(int n, bit tk);
        for (int i = 0; i < n; i++) begin
            tick = tk;
            edge_step(0, 1'b0, tk);
        end
        tick = 1'b0;
    endtask

    task automatic bus_write(int k, logic [11:0] a, logic [31:0] d, bit tk_acc);
        sel = 2'b00; sel[k] = 1'b1; pen = 1'b0; pwr = 1'b1; addr = a; wdata = d; tick = 1'b0;
        edge_step(k, 1'b0, 1'b0);
        pen = 1'b1; tick = tk_acc;
        edge_step(k, 1'b1, tk_acc);
        sel = 2'b00; pen = 1'b0; pwr = 1'b0; tick = 1'b0;
    endtask

    task automatic bus_read_chk(int k, logic [11:0] a, string tag);
        sel = 2'b00; sel[k] = 1'b1; pen = 1'b0; pwr = 1'b0; addr = a; tick = 1'b0;
        edge_step(k, 1'b0, 1'b0);
        pen = 1'b1;
        #1;
        check(tag, $sformatf("read inst%0d addr %h", k, a), rdata[k], exp_read(k, a));
        check("R1", "pready", {31'd0, rdy[k]}, 32'd1);
        edge_step(k, 1'b0, 1'b0);
        sel = 2'b00; pen = 1'b0;
    endtask

    task automatic irq_chk(int k, string tag);
        check(tag, $sformatf("irq inst%0d", k), {31'd0, irq[k]}, {31'd0, m_ris[k] & m_en[k]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sel = 2'b00; pen = 1'b0; tick = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0013));
        model_reset();
        @(negedge clk);
        do_reset();

        // Reset state of both builds.
        for (int k = 0; k < 2; k++) begin
            check("R2", "reset load", exp_read(k, 12'h000), 32'hFFFF_FFFF);
            bus_read_chk(k, 12'h000, "R2");
            bus_read_chk(k, 12'h004, "R2");
            bus_read_chk(k, 12'h008, "R2");
            bus_read_chk(k, 12'h010, "R2");
            bus_read_chk(k, 12'h014, "R2");
            bus_read_chk(k, 12'h00C, "R1");
            bus_read_chk(k, 12'h018, "R1");
            bus_read_chk(k, 12'h404, "R1");
        end

        // R3: no counting after reset while disabled.
        run(15, 1'b1);
        bus_read_chk(0, 12'h004, "R3");
        check("R3", "held after reset", m_val[0], 32'hFFFF_FFFF);

        // R4: load while disabled takes effect and holds.
        bus_write(0, 12'h000, 32'd20, 1'b0);
        bus_read_chk(0, 12'h004, "R4");
        run(5, 1'b1);
        bus_read_chk(0, 12'h004, "R3");

        // R3: enable and count 10 ticks.
        bus_write(0, 12'h008, 32'd1, 1'b0);
        run(10, 1'b1);
        bus_read_chk(0, 12'h004, "R3");
        check("R3", "model after 10 ticks", m_val[0], 32'd10);

        // R5: disable freezes, re-enable reloads.
        bus_write(0, 12'h008, 32'd0, 1'b0);
        run(6, 1'b1);
        bus_read_chk(0, 12'h004, "R5");
        bus_write(0, 12'h008, 32'd1, 1'b0);
        bus_read_chk(0, 12'h004, "R5");

        // R6: run to zero, flag set, then reload on the next tick.
        run(20, 1'b1);
        bus_read_chk(0, 12'h004, "R6");
        bus_read_chk(0, 12'h010, "R6");
        bus_read_chk(0, 12'h014, "R9");
        irq_chk(0, "R9");
        run(1, 1'b1);
        bus_read_chk(0, 12'h004, "R6");

        // R5/R9: disable with the flag set; status stays, irq drops.
        bus_write(0, 12'h008, 32'd0, 1'b0);
        bus_read_chk(0, 12'h010, "R5");
        irq_chk(0, "R9");
        bus_write(0, 12'h008, 32'd1, 1'b0);

        // R7: clear write with arbitrary data.
        run(7, 1'b1);
        bus_write(0, 12'h00C, 32'hDEAD_BEEF, 1'b1);
        bus_read_chk(0, 12'h010, "R7");
        bus_read_chk(0, 12'h004, "R7");

        // R4: load write colliding with a tick.
        bus_write(0, 12'h000, 32'd33, 1'b1);
        bus_read_chk(0, 12'h004, "R4");

        // R7: clear in the same cycle as the tick that reaches zero.
        bus_write(0, 12'h000, 32'd1, 1'b0);
        bus_write(0, 12'h00C, 32'd0, 1'b1);
        bus_read_chk(0, 12'h010, "R7");
        bus_read_chk(0, 12'h004, "R7");

        // R8: locking build ignores disable; plain build honours it.
        bus_write(1, 12'h000, 32'd50, 1'b0);
        bus_write(1, 12'h008, 32'd1, 1'b0);
        run(5, 1'b1);
        bus_write(1, 12'h008, 32'd0, 1'b0);
        run(5, 1'b1);
        bus_read_chk(1, 12'h008, "R8");
        bus_read_chk(1, 12'h004, "R8");
        check("R8", "locked count", m_val[1], 32'd40);
        bus_write(0, 12'h008, 32'd0, 1'b0);
        bus_read_chk(0, 12'h008, "R8");
        do_reset();
        bus_read_chk(1, 12'h008, "R8");
        bus_read_chk(1, 12'h004, "R2");
        run(10, 1'b1);
        bus_read_chk(1, 12'h004, "R3");

        // Seeded random mix across both builds.
        for (int i = 0; i < 600; i++) begin
            int k = $urandom_range(0, 1);
            int op = $urandom_range(0, 9);
            case (op)
                0, 1: bus_write(k, 12'h000, 32'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
                2:    bus_write(k, 12'h008, 32'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
                3:    bus_write(k, 12'h00C, $urandom, 1'($urandom_range(0, 1)));
                4, 5, 6: begin
                    int n = $urandom_range(1, 8);
                    for (int j = 0; j < n; j++) run(1, 1'($urandom_range(0, 1)));
                    irq_chk(k, "R9");
                end
                default: begin
                    logic [11:0] a = 12'(4 * $urandom_range(0, 6));
                    bus_read_chk(k, a, tag_of(a));
                end
            endcase
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule